// File: doc/BRIEF.md
# Interrupt Preemption Arbiter

This block sits between the pending-request selector of an interrupt controller and the processor's exception-entry sequencer. Each cycle it receives the most urgent pending request, the priority of the handler that is running (if any), and the software-controlled settings: priority grouping, a threshold mask and a global disable. From these it decides one of four things. The request may enter directly because nothing is running. It may preempt the running handler. It may be chained straight after the running handler, which is completing in that cycle. Otherwise it is held.

Priorities are 3-bit numbers, and a smaller number means more urgent. A grouping setting splits these bits into an upper preempting group field and a lower subpriority field. Only the group field is compared when deciding preemption, so requests that differ only in subpriority wait for each other and then run back-to-back. The non-maskable request skips every mask, the disable and the grouping. It is always taken at once.

Every decision is registered. The outputs in a cycle reflect the inputs sampled at the previous rising clock edge.

Top module: `irq_preempt_arb`

## Requirements
- R1: While rstN is low, and in the first cycle after it, entryReq, preemptReq, tailChain, heldOut and nmiSel are all 0.
- R2: The grouping setting cfgGroupBits (0..7) gives min(cfgGroupBits,3) preempting bits. These are the most significant bits of the priority, and only they are compared for preemption. Settings 3 through 7 behave identically.
- R3: With cfgGroupBits = 0, a non-NMI candidate never raises preemptReq. It is held while a handler is active and not completing.
- R4: A candidate whose group field equals that of the active handler is held, even when its subpriority is more urgent. If handlerDone is high in that cycle, the candidate raises tailChain instead.
- R5: With a handler active and not completing, an allowed candidate whose group field is numerically strictly lower raises preemptReq.
- R6: cfgMaskLevel = 0 masks nothing. A nonzero level N blocks (holds) every candidate with priority >= N and allows priorities 0..N-1.
- R7: globalDisable = 1 blocks every non-NMI candidate, which is then held. It does not block nmiReq.
- R8: nmiReq = 1 is always taken in the next cycle. It raises entryReq when no handler is active and preemptReq when one is, regardless of mask, disable, grouping or handlerDone, and nmiSel = 1 marks it. A candidate present in the same cycle is held.
- R9: With no handler active (activeValid = 0), an allowed candidate raises entryReq and never preemptReq.
- R10: tailChain is raised only when activeValid, handlerDone and an allowed candidate are all present and nmiReq is absent. In that cycle preemptReq stays 0 for the candidate.
- R11: Each output follows its inputs by exactly one clock. At most one of entryReq, preemptReq and tailChain is high. heldOut is high exactly when a candidate was present and not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgGroupBits | input | 3 | Number of preempting priority bits (values above 3 act as 3) |
| cfgMaskLevel | input | 3 | Threshold mask; 0 = off, N blocks priorities N and above |
| globalDisable | input | 1 | Blocks all non-NMI requests |
| candValid | input | 1 | A pending candidate is presented |
| candPrio | input | 3 | Candidate priority, 0 most urgent |
| nmiReq | input | 1 | Non-maskable request |
| activeValid | input | 1 | A handler is currently running |
| activePrio | input | 3 | Priority of the running handler |
| handlerDone | input | 1 | Running handler completes this cycle |
| entryReq | output | 1 | Enter a handler from the idle context |
| preemptReq | output | 1 | Preempt the running handler |
| tailChain | output | 1 | Chain the candidate after the completing handler |
| heldOut | output | 1 | Candidate present but not taken |
| nmiSel | output | 1 | The taken request is the NMI |

## Verification
A fault in the group-field mask or the threshold compare shows at the ports one clock after the triggering inputs. It appears as a preemptReq where heldOut was due, or the reverse, and only for priority pairs that straddle the affected bit or level. Exhaustive sweeps of priority pairs under every grouping and mask value are needed to expose such faults. A fault in the decision precedence (NMI against candidate, done against preempt) shows as two decision outputs together or a missing nmiSel. That fault too is visible one cycle later. Because the block keeps no state beyond the output register, every error surfaces within a single cycle of its cause.

// File: rtl/irq_preempt_pkg.sv
package irq_preempt_pkg;
  localparam int PRIO_W = 3;
  localparam int GRP_SEL_W = 3;

  typedef struct packed {
    logic candPresent;
    logic candAllowed;
    logic grpLower;
  } dpFlags_t;

  typedef struct packed {
    logic entry;
    logic preempt;
    logic tail;
    logic held;
    logic nmiSel;
  } decision_t;
endpackage

// File: rtl/irq_preempt_dp.sv
module irq_preempt_dp
  import irq_preempt_pkg::*;
#(
  parameter int PW = PRIO_W,
  parameter int SW = GRP_SEL_W
) (
  input  logic [SW-1:0] cfgGroupBits,
  input  logic [PW-1:0] cfgMaskLevel,
  input  logic          globalDisable,
  input  logic          candValid,
  input  logic [PW-1:0] candPrio,
  input  logic [PW-1:0] activePrio,
  output dpFlags_t      flags
);
  localparam logic [SW-1:0] MaxBits = SW'(PW);

  logic [SW-1:0] effBits;
  logic [PW-1:0] grpMask;
  logic [PW-1:0] candGrp;
  logic [PW-1:0] actGrp;
  logic          maskPass;

  assign effBits = (cfgGroupBits > MaxBits) ? MaxBits : cfgGroupBits;

  // bit gi is a group bit when it lies within the top effBits positions
  for (genvar gi = 0; gi < PW; gi++) begin : g_grpMask
    assign grpMask[gi] = (int'(effBits) >= (PW - gi));
  end

  assign candGrp  = candPrio & grpMask;
  assign actGrp   = activePrio & grpMask;
  assign maskPass = (cfgMaskLevel == '0) || (candPrio < cfgMaskLevel);

  assign flags.candPresent = candValid;
  assign flags.candAllowed = candValid && !globalDisable && maskPass;
  assign flags.grpLower    = candGrp < actGrp;
endmodule

// File: rtl/irq_preempt_ctrl.sv
module irq_preempt_ctrl
  import irq_preempt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpFlags_t  flags,
  input  logic      nmiReq,
  input  logic      activeValid,
  input  logic      handlerDone,
  output decision_t decQ
);
  decision_t decD;
  logic      candTaken;

  always_comb begin
    candTaken = flags.candAllowed && !nmiReq &&
                (!activeValid || handlerDone || flags.grpLower);
    decD.nmiSel  = nmiReq;
    decD.entry   = !activeValid && (nmiReq || flags.candAllowed);
    decD.preempt = activeValid &&
                   (nmiReq || (flags.candAllowed && !handlerDone && flags.grpLower));
    decD.tail    = activeValid && handlerDone && !nmiReq && flags.candAllowed;
    decD.held    = flags.candPresent && !candTaken;
  end

  always_ff @(posedge clk) begin
    if (!rstN) decQ <= '0;
    else       decQ <= decD;
  end
endmodule

// File: rtl/irq_preempt_arb.sv
module irq_preempt_arb
  import irq_preempt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [GRP_SEL_W-1:0] cfgGroupBits,
  input  logic [PRIO_W-1:0]    cfgMaskLevel,
  input  logic                 globalDisable,
  input  logic                 candValid,
  input  logic [PRIO_W-1:0]    candPrio,
  input  logic                 nmiReq,
  input  logic                 activeValid,
  input  logic [PRIO_W-1:0]    activePrio,
  input  logic                 handlerDone,
  output logic                 entryReq,
  output logic                 preemptReq,
  output logic                 tailChain,
  output logic                 heldOut,
  output logic                 nmiSel
);
  dpFlags_t  flags;
  decision_t decQ;

  irq_preempt_dp #(.PW(PRIO_W), .SW(GRP_SEL_W)) u_dp (
    .cfgGroupBits (cfgGroupBits),
    .cfgMaskLevel (cfgMaskLevel),
    .globalDisable(globalDisable),
    .candValid    (candValid),
    .candPrio     (candPrio),
    .activePrio   (activePrio),
    .flags        (flags)
  );

  irq_preempt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .flags      (flags),
    .nmiReq     (nmiReq),
    .activeValid(activeValid),
    .handlerDone(handlerDone),
    .decQ       (decQ)
  );

  assign entryReq   = decQ.entry;
  assign preemptReq = decQ.preempt;
  assign tailChain  = decQ.tail;
  assign heldOut    = decQ.held;
  assign nmiSel     = decQ.nmiSel;
endmodule

// File: rtl/irq_preempt_arb_chk.sv
module irq_preempt_arb_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] cfgGroupBits,
  input logic [2:0] cfgMaskLevel,
  input logic       globalDisable,
  input logic       candValid,
  input logic [2:0] candPrio,
  input logic       nmiReq,
  input logic       activeValid,
  input logic       handlerDone,
  input logic       entryReq,
  input logic       preemptReq,
  input logic       tailChain,
  input logic       heldOut,
  input logic       nmiSel
);
  AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({entryReq, preemptReq, tailChain})); // R11
  AST_NMI_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |=> nmiSel && (entryReq || preemptReq)); // R8
  AST_DISABLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (candValid && globalDisable && !nmiReq) |=> heldOut); // R7
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (candValid && cfgMaskLevel != 3'd0 && candPrio >= cfgMaskLevel) |=> heldOut); // R6
  AST_NO_GROUP_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rstN)
    (cfgGroupBits == 3'd0 && !nmiReq) |=> !preemptReq); // R3
  AST_IDLE_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rstN)
    !activeValid |=> !preemptReq); // R9
  AST_TAIL_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !(activeValid && handlerDone) |=> !tailChain); // R10
endmodule

bind irq_preempt_arb irq_preempt_arb_chk u_chk (.*);

// File: tb/irq_preempt_arb_bench.sv
module irq_preempt_arb_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] cfgGroupBits = '0, cfgMaskLevel = '0, candPrio = '0, activePrio = '0;
  logic globalDisable = 1'b0, candValid = 1'b0, nmiReq = 1'b0;
  logic activeValid = 1'b0, handlerDone = 1'b0;
  logic entryReq, preemptReq, tailChain, heldOut, nmiSel;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";

  // inputs applied in the previous cycle
  int pRst = 1, pG = 0, pM = 0, pDis = 0, pCv = 0, pCp = 0, pNmi = 0, pAv = 0, pAp = 0, pDone = 0;

  always #2 clk = ~clk;

  irq_preempt_arb u_irq_preempt_arb (.*);

  function automatic int grpOf(int prio, int setting);
    int bits = (setting > 3) ? 3 : setting;
    return prio / (1 << (3 - bits));
  endfunction

  task automatic expect1(string name, logic act, int exp);
    compared++;
    if (act !== exp[0]) begin
      mismatched++;
      $display("FAIL %s %s actual=%0b expected=%0d", curReq, name, act, exp);
    end
  endtask

  task automatic checkOutputs();
    int eE = 0, eP = 0, eT = 0, eH = 0, eN = 0;
    int allowed;
    if (!pRst) begin
      allowed = pCv && !pDis && (pM == 0 || pCp < pM);
      eN = pNmi;
      if (pNmi) begin
        if (pAv) eP = 1; else eE = 1;
        eH = pCv;
      end else if (!pAv) begin
        eE = allowed; eH = pCv && !allowed;
      end else if (pDone) begin
        eT = allowed; eH = pCv && !allowed;
      end else if (allowed && grpOf(pCp, pG) < grpOf(pAp, pG)) begin
        eP = 1;
      end else begin
        eH = pCv;
      end
    end
    expect1("entryReq", entryReq, eE);
    expect1("preemptReq", preemptReq, eP);
    expect1("tailChain", tailChain, eT);
    expect1("heldOut", heldOut, eH);
    expect1("nmiSel", nmiSel, eN);
  endtask

  task automatic cyc(int rst, int g, int m, int dis, int cv, int cp, int nmi, int av, int ap, int done);
    @(negedge clk);
    checkOutputs();
    rstN = !rst[0]; cfgGroupBits = g[2:0]; cfgMaskLevel = m[2:0]; globalDisable = dis[0];
    candValid = cv[0]; candPrio = cp[2:0]; nmiReq = nmi[0];
    activeValid = av[0]; activePrio = ap[2:0]; handlerDone = done[0];
    pRst = rst; pG = g; pM = m; pDis = dis; pCv = cv; pCp = cp;
    pNmi = nmi; pAv = av; pAp = ap; pDone = done;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    curReq = "R1";
    repeat (3) cyc(1, 3, 0, 0, 1, 0, 1, 0, 0, 0);
    cyc(0, 3, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 3, 0, 0, 0, 0, 0, 0, 0, 0);
    curReq = "R9";
    cyc(0, 3, 0, 0, 1, 5, 0, 0, 0, 0);
    curReq = "R5";
    cyc(0, 3, 0, 0, 1, 2, 0, 1, 4, 0);
    curReq = "R4";
    cyc(0, 2, 0, 0, 1, 4, 0, 1, 5, 0);
    cyc(0, 2, 0, 0, 1, 4, 0, 1, 5, 1);
    curReq = "R2";
    cyc(0, 1, 0, 0, 1, 2, 0, 1, 4, 0);
    cyc(0, 7, 0, 0, 1, 2, 0, 1, 3, 0);
    cyc(0, 1, 0, 0, 1, 2, 0, 1, 3, 0);
    cyc(0, 5, 0, 0, 1, 6, 0, 1, 7, 0);
    curReq = "R3";
    cyc(0, 0, 0, 0, 1, 0, 0, 1, 7, 0);
    curReq = "R6";
    cyc(0, 3, 4, 0, 1, 4, 0, 0, 0, 0);
    cyc(0, 3, 4, 0, 1, 3, 0, 0, 0, 0);
    cyc(0, 3, 0, 0, 1, 7, 0, 0, 0, 0);
    cyc(0, 3, 1, 0, 1, 0, 0, 0, 0, 0);
    cyc(0, 3, 1, 0, 1, 1, 0, 1, 7, 1);
    curReq = "R7";
    cyc(0, 3, 0, 1, 1, 0, 0, 0, 0, 0);
    cyc(0, 3, 0, 1, 1, 0, 1, 0, 0, 0);
    curReq = "R8";
    cyc(0, 0, 1, 1, 1, 0, 1, 1, 0, 0);
    cyc(0, 3, 0, 0, 0, 0, 1, 0, 0, 0);
    curReq = "R10";
    cyc(0, 3, 0, 0, 1, 0, 1, 1, 5, 1);
    cyc(0, 3, 0, 0, 1, 0, 0, 1, 5, 1);
    cyc(0, 3, 0, 0, 0, 0, 0, 1, 5, 1);
    curReq = "R2";
    for (int g = 0; g < 8; g++)
      for (int a = 0; a < 8; a++)
        for (int c = 0; c < 8; c++)
          cyc(0, g, 0, 0, 1, c, 0, 1, a, 0);
    curReq = "R11";
    for (int i = 0; i < 2000; i++)
      cyc(0, $urandom_range(7), $urandom_range(7), ($urandom_range(5) == 0),
          $urandom_range(1), $urandom_range(7), ($urandom_range(7) == 0),
          $urandom_range(1), $urandom_range(7), $urandom_range(1));
    cyc(0, 3, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 3, 0, 0, 0, 0, 0, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule